// File: doc/BRIEF.md
# Tagged Message Receive Matcher

This unit sits at the receive side of a node's network interface. It pairs the headers of arriving messages with receives that the local processor has posted. A posted receive names a source node and an integer tag. Either field may be flagged as match-any. The unit owns a small table of posted receives and picks a winner when a header matches several of them. It drives the handshake of each exchange and reports completion once the data movement, which an external engine carries out, has finished.

Two delivery styles are supported. In the rendezvous style the sender first announces itself with a request header. The unit answers with a clear-to-send reply, and the sender's data header then starts the transfer. In the eager style the data header arrives with no handshake. The unit looks up a match while the payload streams in. When no receive matches, a configuration input decides whether the payload is parked elsewhere, refused or discarded. The poster can also start an exchange itself: if it names a specific source, the unit sends a pull request at once and skips the sender's announcement. The unit moves no data. It issues grant, park, nack and drop strobes, and an external engine acts on them.

Top module: `msg_match_unit`

## Requirements
- R1: A post is written to the lowest free table slot, and `post_idx_o` shows that slot before the post. With all 8 slots in use, `full_o` is 1 and a post is refused, leaving no entry behind.
- R2: An entry matches a header when its source equals the header source or its source match-any flag is set, and its tag equals the header tag or its tag match-any flag is set.
- R3: When several entries match a header, the one posted earliest wins. An exact match gets no preference over a match-any entry.
- R4: A matched request header (`hdr_kind_i`=0) gives one cycle later a clear-to-send pulse that carries the header's source and tag and the winning index. The entry then waits for data and no longer matches request or eager headers.
- R5: A data header (`hdr_kind_i`=2) whose source and tag equal those of a waiting entry gives a grant pulse for that entry one cycle later.
- R6: A matched eager header (`hdr_kind_i`=1) gives a grant pulse with the winning index one cycle later. The entry then stays in transfer.
- R7: An eager header that matches nothing gives one cycle later a park pulse when `unexp_mode_i`=0, a nack pulse when it is 1, and a drop pulse when it is 2 or 3. At most one of grant, nack, drop and park is high in any cycle.
- R8: A request header that matches nothing gives a nack pulse. A data header that matches no waiting entry gives a drop pulse.
- R9: A post with `post_pull_i`=1 and a specific source gives one cycle later a pull pulse that carries the source, the tag, the tag match-any flag and the slot. The entry then accepts only data headers. With a match-any source the pull flag is ignored and the post behaves as an ordinary one.
- R10: `xfer_done_i` naming an entry in transfer gives one cycle later a done pulse with that index and the actual source and tag of the matched message, and frees the slot. Naming any other entry has no effect.
- R11: After reset all pulses are 0, `full_o` is 0 and `post_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| post_valid_i | input | 1 | Post a receive this cycle |
| post_src_i | input | SRC_W | Source the receive expects |
| post_tag_i | input | TAG_W | Tag the receive expects |
| post_any_src_i | input | 1 | Source is match-any |
| post_any_tag_i | input | 1 | Tag is match-any |
| post_pull_i | input | 1 | Receiver starts the exchange |
| full_o | output | 1 | All slots in use; posts refused |
| post_idx_o | output | IDX_W | Slot the next post takes |
| hdr_valid_i | input | 1 | Header present this cycle |
| hdr_kind_i | input | 2 | 0 request, 1 eager, 2 data, 3 none |
| hdr_src_i | input | SRC_W | Header source node |
| hdr_tag_i | input | TAG_W | Header tag |
| unexp_mode_i | input | 2 | Unmatched eager: 0 park, 1 nack, 2/3 drop |
| cts_valid_o | output | 1 | Clear-to-send reply pulse |
| cts_src_o | output | SRC_W | Node the reply goes to |
| cts_tag_o | output | TAG_W | Tag of the reply |
| cts_idx_o | output | IDX_W | Entry that answered |
| pull_valid_o | output | 1 | Receiver-initiated request pulse |
| pull_src_o | output | SRC_W | Node asked to send |
| pull_tag_o | output | TAG_W | Tag asked for |
| pull_any_tag_o | output | 1 | Any tag is accepted |
| pull_idx_o | output | IDX_W | Entry that issued the request |
| grant_o | output | 1 | Start transfer into an entry's buffer |
| grant_idx_o | output | IDX_W | Entry granted |
| nack_o | output | 1 | Header refused |
| drop_o | output | 1 | Payload discarded |
| park_o | output | 1 | Payload to be held unmatched |
| xfer_done_i | input | 1 | Data movement finished |
| xfer_idx_i | input | IDX_W | Entry whose movement finished |
| done_valid_o | output | 1 | Completion pulse |
| done_idx_o | output | IDX_W | Completed entry |
| done_src_o | output | SRC_W | Actual source of the message |
| done_tag_o | output | TAG_W | Actual tag of the message |

## Verification
The assertions take three things for granted: reset is applied before any traffic, at most one header and one post arrive per cycle, and `xfer_done_i` may name any slot because the design filters it. The bench drives one operation per cycle and never combines a post with a header. Every header outcome, grant index and completion field is therefore the result of one known table state. Expected verdicts come from the matching rule evaluated arithmetically in the bench over every combination of match-any flags and equal or differing source and tag.

// File: rtl/msg_match_pkg.sv
package msg_match_pkg;
  typedef enum logic [2:0] {
    ST_FREE   = 3'd0,
    ST_POSTED = 3'd1,
    ST_PULL   = 3'd2,
    ST_WAIT   = 3'd3,
    ST_XFER   = 3'd4
  } ent_st_e;

  localparam logic [1:0] HK_RTS   = 2'd0;
  localparam logic [1:0] HK_EAGER = 2'd1;
  localparam logic [1:0] HK_DATA  = 2'd2;

  localparam logic [1:0] UX_PARK  = 2'd0;
  localparam logic [1:0] UX_NACK  = 2'd1;
endpackage

// File: rtl/mm_alloc.sv
module mm_alloc #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     busy_i,
  output logic [IDX_W-1:0] free_idx_o,
  output logic             any_free_o
);
  always_comb begin
    free_idx_o = '0;
    any_free_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        free_idx_o = IDX_W'(i);
        any_free_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mm_pick.sv
module mm_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     cand_i,
  input  logic [N-1:0]     older_i [N],
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] win;

  // Entry wins when no other candidate was posted before it.
  for (genvar gi = 0; gi < N; gi++) begin : g_win
    logic [N-1:0] beats_me;
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      assign beats_me[gj] = older_i[gj][gi];
    end
    assign win[gi] = cand_i[gi] && !(|(cand_i & beats_me));
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
  assign hit_o = |win;

  assert_single_winner_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win));
  assert_hit_has_cand_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cand_i) |-> hit_o);
endmodule

// File: rtl/mm_table.sv
module mm_table
  import msg_match_pkg::*;
#(
  parameter int N     = 8,
  parameter int SRC_W = 4,
  parameter int TAG_W = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             post_we_i,
  input  logic [IDX_W-1:0] post_slot_i,
  input  logic [SRC_W-1:0] post_src_i,
  input  logic [TAG_W-1:0] post_tag_i,
  input  logic             post_any_src_i,
  input  logic             post_any_tag_i,
  input  logic             post_pull_i,
  input  logic             hit_we_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  ent_st_e          hit_state_i,
  input  logic             fin_we_i,
  input  logic [IDX_W-1:0] fin_idx_i,
  input  logic [SRC_W-1:0] key_src_i,
  input  logic [TAG_W-1:0] key_tag_i,
  output ent_st_e          st_o    [N],
  output logic [SRC_W-1:0] src_o   [N],
  output logic [TAG_W-1:0] tag_o   [N],
  output logic [N-1:0]     busy_o,
  output logic [N-1:0]     open_o,
  output logic [N-1:0]     wait_o,
  output logic [N-1:0]     older_o [N]
);
  ent_st_e          st_q    [N];
  logic [SRC_W-1:0] src_q   [N];
  logic [TAG_W-1:0] tag_q   [N];
  logic [N-1:0]     any_s_q;
  logic [N-1:0]     any_t_q;
  logic [N-1:0]     older_q [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_ent
    logic post_me, hit_me, fin_me, key_ok;
    assign post_me = post_we_i && (post_slot_i == IDX_W'(gi));
    assign hit_me  = hit_we_i  && (hit_idx_i   == IDX_W'(gi));
    assign fin_me  = fin_we_i  && (fin_idx_i   == IDX_W'(gi));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[gi]    <= ST_FREE;
        src_q[gi]   <= '0;
        tag_q[gi]   <= '0;
        any_s_q[gi] <= 1'b0;
        any_t_q[gi] <= 1'b0;
      end else if (post_me) begin
        st_q[gi]    <= post_pull_i ? ST_PULL : ST_POSTED;
        src_q[gi]   <= post_src_i;
        tag_q[gi]   <= post_tag_i;
        any_s_q[gi] <= post_any_src_i;
        any_t_q[gi] <= post_any_tag_i;
      end else if (hit_me) begin
        // Resolve wildcards to the actual header fields.
        st_q[gi]    <= hit_state_i;
        src_q[gi]   <= key_src_i;
        tag_q[gi]   <= key_tag_i;
        any_s_q[gi] <= 1'b0;
        any_t_q[gi] <= 1'b0;
      end else if (fin_me) begin
        st_q[gi]    <= ST_FREE;
      end
    end

    // Age row: a new entry is older than nobody; every live entry is older than it.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        older_q[gi] <= '0;
      end else if (post_me) begin
        older_q[gi] <= '0;
      end else if (post_we_i) begin
        older_q[gi][post_slot_i] <= busy_o[gi];
      end
    end

    assign key_ok = (any_s_q[gi] || (src_q[gi] == key_src_i)) &&
                    (any_t_q[gi] || (tag_q[gi] == key_tag_i));
    assign busy_o[gi]  = (st_q[gi] != ST_FREE);
    assign open_o[gi]  = (st_q[gi] == ST_POSTED) && key_ok;
    assign wait_o[gi]  = ((st_q[gi] == ST_PULL) || (st_q[gi] == ST_WAIT)) && key_ok;
    assign st_o[gi]    = st_q[gi];
    assign src_o[gi]   = src_q[gi];
    assign tag_o[gi]   = tag_q[gi];
    assign older_o[gi] = older_q[gi];
  end

  assert_post_free_slot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_we_i |-> !busy_o[post_slot_i]);
  assert_hit_live_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_we_i |-> (busy_o[hit_idx_i] && (st_q[hit_idx_i] != ST_XFER)));
endmodule

// File: rtl/msg_match_unit.sv
module msg_match_unit
  import msg_match_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int SRC_W   = 4,
  parameter int TAG_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             post_valid_i,
  input  logic [SRC_W-1:0] post_src_i,
  input  logic [TAG_W-1:0] post_tag_i,
  input  logic             post_any_src_i,
  input  logic             post_any_tag_i,
  input  logic             post_pull_i,
  output logic             full_o,
  output logic [IDX_W-1:0] post_idx_o,
  input  logic             hdr_valid_i,
  input  logic [1:0]       hdr_kind_i,
  input  logic [SRC_W-1:0] hdr_src_i,
  input  logic [TAG_W-1:0] hdr_tag_i,
  input  logic [1:0]       unexp_mode_i,
  output logic             cts_valid_o,
  output logic [SRC_W-1:0] cts_src_o,
  output logic [TAG_W-1:0] cts_tag_o,
  output logic [IDX_W-1:0] cts_idx_o,
  output logic             pull_valid_o,
  output logic [SRC_W-1:0] pull_src_o,
  output logic [TAG_W-1:0] pull_tag_o,
  output logic             pull_any_tag_o,
  output logic [IDX_W-1:0] pull_idx_o,
  output logic             grant_o,
  output logic [IDX_W-1:0] grant_idx_o,
  output logic             nack_o,
  output logic             drop_o,
  output logic             park_o,
  input  logic             xfer_done_i,
  input  logic [IDX_W-1:0] xfer_idx_i,
  output logic             done_valid_o,
  output logic [IDX_W-1:0] done_idx_o,
  output logic [SRC_W-1:0] done_src_o,
  output logic [TAG_W-1:0] done_tag_o
);
  ent_st_e              st    [ENTRIES];
  logic [SRC_W-1:0]     src   [ENTRIES];
  logic [TAG_W-1:0]     tag   [ENTRIES];
  logic [ENTRIES-1:0]   older [ENTRIES];
  logic [ENTRIES-1:0]   busy, open_m, wait_m, cand;
  logic [IDX_W-1:0]     free_idx, hit_idx;
  logic                 any_free, hit;
  logic                 is_rts, is_eager, is_data, post_ok, pull_eff, fin;
  ent_st_e              hit_state;

  assign is_rts   = hdr_valid_i && (hdr_kind_i == HK_RTS);
  assign is_eager = hdr_valid_i && (hdr_kind_i == HK_EAGER);
  assign is_data  = hdr_valid_i && (hdr_kind_i == HK_DATA);
  assign post_ok  = post_valid_i && any_free;
  assign pull_eff = post_pull_i && !post_any_src_i;
  assign fin      = xfer_done_i && (st[xfer_idx_i] == ST_XFER);

  always_comb begin
    cand = '0;
    if (is_data)               cand = wait_m;
    else if (is_rts || is_eager) cand = open_m;
  end
  assign hit_state = is_rts ? ST_WAIT : ST_XFER;

  mm_alloc #(.N(ENTRIES), .IDX_W(IDX_W)) alloc_i (
    .busy_i(busy), .free_idx_o(free_idx), .any_free_o(any_free)
  );

  mm_pick #(.N(ENTRIES), .IDX_W(IDX_W)) pick_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cand_i(cand), .older_i(older),
    .hit_o(hit), .idx_o(hit_idx)
  );

  mm_table #(.N(ENTRIES), .SRC_W(SRC_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) table_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .post_we_i(post_ok), .post_slot_i(free_idx),
    .post_src_i(post_src_i), .post_tag_i(post_tag_i),
    .post_any_src_i(post_any_src_i), .post_any_tag_i(post_any_tag_i),
    .post_pull_i(pull_eff),
    .hit_we_i(hit), .hit_idx_i(hit_idx), .hit_state_i(hit_state),
    .fin_we_i(fin), .fin_idx_i(xfer_idx_i),
    .key_src_i(hdr_src_i), .key_tag_i(hdr_tag_i),
    .st_o(st), .src_o(src), .tag_o(tag), .busy_o(busy),
    .open_o(open_m), .wait_o(wait_m), .older_o(older)
  );

  assign full_o     = !any_free;
  assign post_idx_o = free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cts_valid_o    <= 1'b0;
      cts_src_o      <= '0;
      cts_tag_o      <= '0;
      cts_idx_o      <= '0;
      pull_valid_o   <= 1'b0;
      pull_src_o     <= '0;
      pull_tag_o     <= '0;
      pull_any_tag_o <= 1'b0;
      pull_idx_o     <= '0;
      grant_o        <= 1'b0;
      grant_idx_o    <= '0;
      nack_o         <= 1'b0;
      drop_o         <= 1'b0;
      park_o         <= 1'b0;
      done_valid_o   <= 1'b0;
      done_idx_o     <= '0;
      done_src_o     <= '0;
      done_tag_o     <= '0;
    end else begin
      cts_valid_o    <= is_rts && hit;
      cts_src_o      <= hdr_src_i;
      cts_tag_o      <= hdr_tag_i;
      cts_idx_o      <= hit_idx;
      pull_valid_o   <= post_ok && pull_eff;
      pull_src_o     <= post_src_i;
      pull_tag_o     <= post_tag_i;
      pull_any_tag_o <= post_any_tag_i;
      pull_idx_o     <= free_idx;
      grant_o        <= (is_eager || is_data) && hit;
      grant_idx_o    <= hit_idx;
      nack_o         <= (is_rts && !hit) ||
                        (is_eager && !hit && (unexp_mode_i == UX_NACK));
      park_o         <= is_eager && !hit && (unexp_mode_i == UX_PARK);
      drop_o         <= (is_data && !hit) || (is_eager && !hit && unexp_mode_i[1]);
      done_valid_o   <= fin;
      done_idx_o     <= xfer_idx_i;
      done_src_o     <= src[xfer_idx_i];
      done_tag_o     <= tag[xfer_idx_i];
    end
  end

  assert_one_verdict_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, nack_o, drop_o, park_o}));
  assert_refuse_when_full_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && post_valid_i) |=> ($countones(busy) <= $past($countones(busy))));
  assert_grant_in_xfer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (st[grant_idx_o] == ST_XFER));
  assert_cts_from_request_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cts_valid_o |-> ($past(is_rts) && (st[cts_idx_o] == ST_WAIT)));
  assert_pull_entry_waits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_valid_o |-> (st[pull_idx_o] == ST_PULL));
  assert_done_frees_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> ($past(xfer_done_i) && (st[done_idx_o] == ST_FREE)));
endmodule

// File: tb/msg_match_unit_tb.sv
`timescale 1ns/1ps
module msg_match_unit_tb_top;
  localparam int N = 8, SW = 4, TW = 8, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic post_valid = 0, post_any_src = 0, post_any_tag = 0, post_pull = 0;
  logic [SW-1:0] post_src = '0;
  logic [TW-1:0] post_tag = '0;
  logic full;
  logic [IW-1:0] post_idx;
  logic hdr_valid = 0;
  logic [1:0] hdr_kind = 2'd3, unexp_mode = 2'd2;
  logic [SW-1:0] hdr_src = '0;
  logic [TW-1:0] hdr_tag = '0;
  logic cts_valid, pull_valid, pull_any_tag, grant, nack, drop, park, done_valid;
  logic [SW-1:0] cts_src, pull_src, done_src;
  logic [TW-1:0] cts_tag, pull_tag, done_tag;
  logic [IW-1:0] cts_idx, pull_idx, grant_idx, done_idx;
  logic xfer_done = 0;
  logic [IW-1:0] xfer_idx = '0;

  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  msg_match_unit #(.ENTRIES(N), .SRC_W(SW), .TAG_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .post_valid_i(post_valid), .post_src_i(post_src), .post_tag_i(post_tag),
    .post_any_src_i(post_any_src), .post_any_tag_i(post_any_tag), .post_pull_i(post_pull),
    .full_o(full), .post_idx_o(post_idx),
    .hdr_valid_i(hdr_valid), .hdr_kind_i(hdr_kind), .hdr_src_i(hdr_src), .hdr_tag_i(hdr_tag),
    .unexp_mode_i(unexp_mode),
    .cts_valid_o(cts_valid), .cts_src_o(cts_src), .cts_tag_o(cts_tag), .cts_idx_o(cts_idx),
    .pull_valid_o(pull_valid), .pull_src_o(pull_src), .pull_tag_o(pull_tag),
    .pull_any_tag_o(pull_any_tag), .pull_idx_o(pull_idx),
    .grant_o(grant), .grant_idx_o(grant_idx), .nack_o(nack), .drop_o(drop), .park_o(park),
    .xfer_done_i(xfer_done), .xfer_idx_i(xfer_idx),
    .done_valid_o(done_valid), .done_idx_o(done_idx), .done_src_o(done_src), .done_tag_o(done_tag)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic post(input int s, input int t, input bit as, input bit at, input bit pl);
    post_valid = 1; post_src = SW'(s); post_tag = TW'(t);
    post_any_src = as; post_any_tag = at; post_pull = pl;
    step();
    post_valid = 0; post_pull = 0; post_any_src = 0; post_any_tag = 0;
  endtask

  task automatic hdr(input logic [1:0] k, input int s, input int t);
    hdr_valid = 1; hdr_kind = k; hdr_src = SW'(s); hdr_tag = TW'(t);
    step();
    hdr_valid = 0; hdr_kind = 2'd3;
  endtask

  // Verdict code: grant=8 nack=4 drop=2 park=1.
  task automatic verdict(input string req, input int exp_code, input int exp_idx);
    int code;
    code = {28'd0, grant, nack, drop, park};
    chk(code == exp_code, req, code, exp_code);
    if (exp_code == 8) chk(int'(grant_idx) == exp_idx, {req, " grant index"}, int'(grant_idx), exp_idx);
  endtask

  task automatic finish_xfer(input string req, input int idx, input int s, input int t);
    xfer_done = 1; xfer_idx = IW'(idx);
    step();
    xfer_done = 0;
    chk(done_valid == 1'b1, {req, " done pulse"}, int'(done_valid), 1);
    chk(int'(done_idx) == idx, {req, " done index"}, int'(done_idx), idx);
    chk(int'(done_src) == s, {req, " done source"}, int'(done_src), s);
    chk(int'(done_tag) == t, {req, " done tag"}, int'(done_tag), t);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(full == 0, "R11 full", int'(full), 0);
    chk(post_idx == 0, "R11 post index", int'(post_idx), 0);
    chk({cts_valid, pull_valid, grant, nack, drop, park, done_valid} == 7'd0,
        "R11 pulses", int'({cts_valid, pull_valid, grant, nack, drop, park, done_valid}), 0);

    // R1 fill the table, refuse when full
    for (int i = 0; i < N; i++) begin
      chk(int'(post_idx) == i, "R1 lowest free slot", int'(post_idx), i);
      post(i, 16 + i, 0, 0, 0);
    end
    chk(full == 1, "R1 full flag", int'(full), 1);
    post(9, 99, 0, 0, 0);
    unexp_mode = 2'd0;
    hdr(2'd1, 9, 99);
    verdict("R1 refused post left no entry", 1, 0);
    unexp_mode = 2'd2;
    for (int i = 0; i < N; i++) begin
      hdr(2'd1, i, 16 + i);
      verdict("R6 eager grant", 8, i);
      finish_xfer("R10", i, i, 16 + i);
    end
    chk(full == 0, "R1 full cleared", int'(full), 0);

    // R2 wildcard sweep over flags and equal/differing fields
    for (int m = 0; m < 16; m++) begin
      bit as, at, ds, dt, hit;
      as = m[0]; at = m[1]; ds = m[2]; dt = m[3];
      hit = (as || !ds) && (at || !dt);
      post(3, 40, as, at, 0);
      hdr(2'd1, 3 + int'(ds), 40 + int'(dt));
      if (hit) begin
        verdict("R2 wildcard match", 8, 0);
        finish_xfer("R2 resolved fields", 0, 3 + int'(ds), 40 + int'(dt));
      end else begin
        verdict("R2 wildcard miss", 2, 0);
        hdr(2'd1, 3, 40);
        verdict("R2 entry kept after miss", 8, 0);
        finish_xfer("R2", 0, 3, 40);
      end
    end

    // R3 posting order decides, exactness does not
    post(1, 1, 0, 0, 0);
    post(0, 0, 1, 1, 0);
    post(2, 2, 0, 0, 0);
    hdr(2'd1, 1, 1);
    verdict("R3 oldest exact beats newer wildcard", 8, 0);
    finish_xfer("R3", 0, 1, 1);
    post(7, 7, 0, 0, 0);
    hdr(2'd1, 7, 7);
    verdict("R3 older wildcard beats newer exact", 8, 1);
    finish_xfer("R3", 1, 7, 7);
    hdr(2'd1, 7, 7);
    verdict("R3 next candidate", 8, 0);
    finish_xfer("R3", 0, 7, 7);
    hdr(2'd1, 2, 2);
    verdict("R3 remaining entry", 8, 2);
    finish_xfer("R3", 2, 2, 2);

    // R4/R5 rendezvous path
    post(0, 0, 1, 1, 0);
    hdr(2'd0, 6, 12);
    chk(cts_valid == 1, "R4 cts pulse", int'(cts_valid), 1);
    chk(int'(cts_src) == 6, "R4 cts source", int'(cts_src), 6);
    chk(int'(cts_tag) == 12, "R4 cts tag", int'(cts_tag), 12);
    chk(int'(cts_idx) == 0, "R4 cts index", int'(cts_idx), 0);
    verdict("R4 no verdict on request", 0, 0);
    unexp_mode = 2'd0;
    hdr(2'd1, 6, 12);
    verdict("R4 waiting entry not eager-matchable", 1, 0);
    hdr(2'd0, 6, 12);
    verdict("R4 waiting entry not request-matchable", 4, 0);
    hdr(2'd2, 6, 13);
    verdict("R5 data tag mismatch", 2, 0);
    hdr(2'd2, 5, 12);
    verdict("R5 data source mismatch", 2, 0);
    hdr(2'd2, 6, 12);
    verdict("R5 data grant", 8, 0);
    finish_xfer("R5", 0, 6, 12);

    // R7/R8 unmatched headers on an empty table
    for (int md = 0; md < 4; md++) begin
      int exp_c;
      unexp_mode = 2'(md);
      exp_c = (md == 0) ? 1 : (md == 1) ? 4 : 2;
      hdr(2'd1, 1, 1);
      verdict("R7 unmatched eager action", exp_c, 0);
    end
    hdr(2'd0, 1, 1);
    verdict("R8 unmatched request nack", 4, 0);
    hdr(2'd2, 1, 1);
    verdict("R8 unmatched data drop", 2, 0);

    // R9 receiver-initiated exchange
    post(5, 0, 0, 1, 1);
    chk(pull_valid == 1, "R9 pull pulse", int'(pull_valid), 1);
    chk(int'(pull_src) == 5, "R9 pull source", int'(pull_src), 5);
    chk(pull_any_tag == 1, "R9 pull any tag", int'(pull_any_tag), 1);
    chk(int'(pull_idx) == 0, "R9 pull index", int'(pull_idx), 0);
    hdr(2'd0, 5, 7);
    verdict("R9 request ignored by pull entry", 4, 0);
    unexp_mode = 2'd1;
    hdr(2'd1, 5, 7);
    verdict("R9 eager ignored by pull entry", 4, 0);
    hdr(2'd2, 5, 7);
    verdict("R9 data grant", 8, 0);
    finish_xfer("R9", 0, 5, 7);
    post(0, 3, 1, 0, 1);
    chk(pull_valid == 0, "R9 wildcard source no pull", int'(pull_valid), 0);
    hdr(2'd1, 4, 3);
    verdict("R9 wildcard pull acts as ordinary", 8, 0);
    finish_xfer("R9", 0, 4, 3);

    // R10 stray completions ignored
    post(2, 2, 0, 0, 0);
    xfer_done = 1; xfer_idx = 3'd0;
    step();
    chk(done_valid == 0, "R10 done on posted entry ignored", int'(done_valid), 0);
    xfer_idx = 3'd5;
    step();
    xfer_done = 0;
    chk(done_valid == 0, "R10 done on free slot ignored", int'(done_valid), 0);
    hdr(2'd1, 2, 2);
    verdict("R10 entry intact after stray done", 8, 0);
    finish_xfer("R10", 0, 2, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule